// File: doc/BRIEF.md
# Forward-Channel Parallel-Port Host Transmitter

This block is the host end of the forward direction of an extended-capability parallel-port link. It takes one byte at a time from a valid/ready queue head. Each byte is tagged as plain data, as a run-length count command, or as a channel-address command. The block places the byte on the eight data lines and sets the host acknowledge line to mark the byte as data or command. It then runs the four-phase strobe handshake against the peripheral's acknowledge line.

A byte counts as delivered only at the instant the host strobe returns high. At that edge the byte is taken from the queue head and a wrapping transfer counter steps. An abort request before that point abandons the attempt: nothing is counted and the byte stays at the head for a retry. A configurable timeout guards both waits on the peripheral. When it expires, the block raises an error flag and returns to rest.

The controller has four states:
- **IDLE**: at rest.
- **SETUP**: lines are driven and the strobe is still high.
- **STROBE**: the strobe is low, waiting for the acknowledge to rise.
- **RELEASE**: the strobe is high again, waiting for the acknowledge to fall.

The transitions are:
- **T_START**: IDLE to SETUP.
- **T_SETUP_DONE**: SETUP to STROBE.
- **T_COMMIT**: STROBE to RELEASE.
- **T_ACK_LOW**: RELEASE to IDLE.
- **T_ABORT**: SETUP or STROBE to IDLE.
- **T_TIMEOUT**: STROBE or RELEASE to IDLE.

Top module: `ecpfwd_host_tx`

## Requirements
- R1: While reset is high and on the cycle after it, the strobe is high, the host acknowledge is high, the counter is zero, and the done and error flags are low.
- R2: A byte tagged data (in_kind_i = 2'b00) is driven unchanged on the data lines, with the host acknowledge high.
- R3: A command byte drives the host acknowledge low. Kind 2'b01 (run-length count) drives bit 7 = 0 and bits 6:0 = payload bits 6:0. Kind 2'b10 or 2'b11 (channel address) drives bit 7 = 1 and bits 6:0 = payload bits 6:0. Payload bit 7 is dropped for commands.
- R4: From IDLE, a valid head drives the data lines and host acknowledge on the next edge. The strobe falls exactly cfg_setup_clks_i + 1 clocks later. Lines stay stable while the strobe is low.
- R5: The strobe stays low until the peripheral acknowledge has passed a two-flop synchroniser. The strobe rises on the third clock edge after the acknowledge pin goes high.
- R6: The rising strobe is the commit point. in_ready_o is high for the one cycle before that edge. On that edge the counter increments and byte_done_o pulses for one cycle.
- R7: After a commit, no new byte is driven until the synchronised peripheral acknowledge is low again.
- R8: abort_i in SETUP or STROBE returns the strobe high with no pop, no count step and no done pulse. A later retry of the same byte is counted once.
- R9: If the acknowledge does not rise, the strobe stays low for cfg_timeout_clks_i + 1 cycles. The block then raises timeout_err_o, returns the strobe high and counts nothing.
- R10: If the acknowledge does not fall after a commit, timeout_err_o rises cfg_timeout_clks_i + 1 cycles after the commit edge. The committed byte stays counted.
- R11: timeout_err_o stays high until the next byte starts (T_START), which clears it.
- R12: The transfer counter wraps modulo 2^CNT_W.
- R13: Data and command bytes may follow each other in any order, each with its own full handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| in_valid_i | input | 1 | Queue head holds a byte |
| in_kind_i | input | 2 | 00 data, 01 run-length count, 1x channel address |
| in_payload_i | input | 8 | Byte value (bits 6:0 only for commands) |
| in_ready_o | output | 1 | Pop strobe, high in the commit cycle |
| abort_i | input | 1 | Abandon the byte in flight before commit |
| cfg_setup_clks_i | input | SETUP_W | Extra setup clocks before the strobe falls |
| cfg_timeout_clks_i | input | TMO_W | Wait limit on the peripheral acknowledge |
| periph_ack_i | input | 1 | Peripheral acknowledge pin (asynchronous) |
| pd_o | output | 8 | Parallel data lines |
| host_ack_o | output | 1 | High for data, low for command |
| host_clk_o | output | 1 | Host strobe, active low |
| byte_done_o | output | 1 | One-cycle pulse per committed byte |
| xfer_count_o | output | CNT_W | Committed-byte counter |
| timeout_err_o | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with CNT_W = 4, SETUP_W = 3 and TMO_W = 5. The 4-bit counter wraps after sixteen bytes, so the wrap is reached in a short run. The setup range is small enough to test both ends of it, 0 and 7. A timeout value of 12 keeps both timeout paths short while leaving room for the peripheral delays the bench uses.

// File: rtl/ecpfwd_pkg.sv
package ecpfwd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RELEASE
    } fwd_state_t;

    localparam logic [1:0] KIND_DATA  = 2'b00;
    localparam logic [1:0] KIND_COUNT = 2'b01;

    // Returns {host_ack_level, data_lines}.
    function automatic logic [8:0] build_lines(input logic [1:0] kind,
                                               input logic [7:0] payload);
        logic [8:0] r;
        if (kind[1])
            r = {1'b0, 1'b1, payload[6:0]};
        else if (kind[0])
            r = {1'b0, 1'b0, payload[6:0]};
        else
            r = {1'b1, payload};
        return r;
    endfunction

endpackage

// File: rtl/ecpfwd_sync2.sv
module ecpfwd_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ecpfwd_cycle_timer.sv
module ecpfwd_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    output logic [W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i)
            count_o <= '0;
        else if (!(&count_o))
            count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/ecpfwd_xfer_count.sv
module ecpfwd_xfer_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    output logic [W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (rst)
            count_o <= '0;
        else if (step_i)
            count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/ecpfwd_host_tx.sv
module ecpfwd_host_tx
    import ecpfwd_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SETUP_W     = 4,
    parameter int TMO_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid_i,
    input  logic [1:0]         in_kind_i,
    input  logic [7:0]         in_payload_i,
    output logic               in_ready_o,
    input  logic               abort_i,
    input  logic [SETUP_W-1:0] cfg_setup_clks_i,
    input  logic [TMO_W-1:0]   cfg_timeout_clks_i,
    input  logic               periph_ack_i,
    output logic [7:0]         pd_o,
    output logic               host_ack_o,
    output logic               host_clk_o,
    output logic               byte_done_o,
    output logic [CNT_W-1:0]   xfer_count_o,
    output logic               timeout_err_o
);
    localparam int TMR_W = (SETUP_W > TMO_W) ? SETUP_W : TMO_W;

    fwd_state_t       state_q, state_n;
    logic             ack_s;
    logic [TMR_W-1:0] tmr;
    logic             tmr_clr;
    logic             setup_done, tmo_hit;
    logic             t_start, t_commit, t_timeout;

    ecpfwd_sync2 #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (periph_ack_i),
        .sync_o  (ack_s)
    );

    ecpfwd_cycle_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (tmr_clr),
        .count_o (tmr)
    );

    ecpfwd_xfer_count #(.W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .step_i  (t_commit),
        .count_o (xfer_count_o)
    );

    assign setup_done = (tmr == TMR_W'(cfg_setup_clks_i));
    assign tmo_hit    = (tmr == TMR_W'(cfg_timeout_clks_i));
    assign tmr_clr    = (state_n != state_q);
    assign in_ready_o = t_commit;

    // Next-state and transition decode
    always_comb begin
        state_n   = state_q;
        t_start   = 1'b0;
        t_commit  = 1'b0;
        t_timeout = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid_i) begin
                    state_n = ST_SETUP;
                    t_start = 1'b1;
                end
            end
            ST_SETUP: begin
                if (abort_i)
                    state_n = ST_IDLE;
                else if (setup_done)
                    state_n = ST_STROBE;
            end
            ST_STROBE: begin
                if (abort_i) begin
                    state_n = ST_IDLE;
                end else if (ack_s) begin
                    state_n  = ST_RELEASE;
                    t_commit = 1'b1;
                end else if (tmo_hit) begin
                    state_n   = ST_IDLE;
                    t_timeout = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (!ack_s) begin
                    state_n = ST_IDLE;
                end else if (tmo_hit) begin
                    state_n   = ST_IDLE;
                    t_timeout = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    // Registered line outputs and flags
    always_ff @(posedge clk) begin
        if (rst) begin
            host_clk_o    <= 1'b1;
            host_ack_o    <= 1'b1;
            pd_o          <= '0;
            byte_done_o   <= 1'b0;
            timeout_err_o <= 1'b0;
        end else begin
            host_clk_o  <= (state_n != ST_STROBE);
            byte_done_o <= t_commit;
            if (t_start) begin
                {host_ack_o, pd_o} <= build_lines(in_kind_i, in_payload_i);
                timeout_err_o      <= 1'b0;
            end else if (t_timeout) begin
                timeout_err_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ecpfwd_host_tx_chk.sv
module ecpfwd_host_tx_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready_o,
    input logic             abort_i,
    input logic [7:0]       pd_o,
    input logic             host_ack_o,
    input logic             host_clk_o,
    input logic             byte_done_o,
    input logic [CNT_W-1:0] xfer_count_o,
    input logic             timeout_err_o
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> host_clk_o && host_ack_o && xfer_count_o == '0 && !byte_done_o && !timeout_err_o);

    p_lines_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !host_clk_o |-> $stable(pd_o) && $stable(host_ack_o));

    p_pop_in_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        in_ready_o |-> !host_clk_o);

    p_pop_commits_r6: assert property (@(posedge clk) disable iff (rst)
        in_ready_o |=> byte_done_o && host_clk_o);

    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        byte_done_o |-> xfer_count_o == CNT_W'($past(xfer_count_o) + 1'b1));

    p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_ready_o |=> $stable(xfer_count_o));

    p_abort_no_pop_r8: assert property (@(posedge clk) disable iff (rst)
        abort_i |-> !in_ready_o);

    p_err_no_done_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err_o) |-> !byte_done_o);
endmodule

bind ecpfwd_host_tx ecpfwd_host_tx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_ready_o    (in_ready_o),
    .abort_i       (abort_i),
    .pd_o          (pd_o),
    .host_ack_o    (host_ack_o),
    .host_clk_o    (host_clk_o),
    .byte_done_o   (byte_done_o),
    .xfer_count_o  (xfer_count_o),
    .timeout_err_o (timeout_err_o)
);

// File: tb/ecpfwd_host_tx_tb.sv
module ecpfwd_host_tx_tb_top;
    localparam int CNT_W   = 4;
    localparam int SETUP_W = 3;
    localparam int TMO_W   = 5;
    localparam int TMO     = 12;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [1:0]         in_kind = 2'b00;
    logic [7:0]         in_payload = 8'h00;
    logic               in_ready;
    logic               abort_req = 1'b0;
    logic [SETUP_W-1:0] cfg_setup = '0;
    logic [TMO_W-1:0]   cfg_tmo = TMO_W'(TMO);
    logic               periph_ack = 1'b0;
    logic [7:0]         pd;
    logic               host_ack, host_clk, byte_done, tmo_err;
    logic [CNT_W-1:0]   xcount;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;

    always #2 clk = ~clk;

    ecpfwd_host_tx #(.CNT_W(CNT_W), .SETUP_W(SETUP_W), .TMO_W(TMO_W)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid_i(in_valid), .in_kind_i(in_kind), .in_payload_i(in_payload),
        .in_ready_o(in_ready), .abort_i(abort_req),
        .cfg_setup_clks_i(cfg_setup), .cfg_timeout_clks_i(cfg_tmo),
        .periph_ack_i(periph_ack),
        .pd_o(pd), .host_ack_o(host_ack), .host_clk_o(host_clk),
        .byte_done_o(byte_done), .xfer_count_o(xcount), .timeout_err_o(tmo_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [8:0] expect_lines(input logic [1:0] k, input logic [7:0] p);
        if (k[1])      return {1'b0, 1'b1, p[6:0]};
        else if (k[0]) return {1'b0, 1'b0, p[6:0]};
        else           return {1'b1, p};
    endfunction

    task automatic present(input logic [1:0] k, input logic [7:0] p);
        @(negedge clk);
        in_valid   = 1'b1;
        in_kind    = k;
        in_payload = p;
    endtask

    // Returns the number of samples with strobe still high after presenting.
    task automatic wait_strobe(output int hi_n);
        hi_n = 0;
        @(negedge clk);
        while (host_clk && hi_n < 100) begin
            hi_n++;
            @(negedge clk);
        end
    endtask

    // Raises the acknowledge now; returns samples with strobe low and pop seen.
    task automatic ack_commit(output int lo_n, output bit popped);
        periph_ack = 1'b1;
        lo_n = 0;
        popped = 1'b0;
        @(negedge clk);
        while (!host_clk && lo_n < 100) begin
            if (in_ready) popped = 1'b1;
            lo_n++;
            @(negedge clk);
        end
    endtask

    task automatic send_byte(input logic [1:0] k, input logic [7:0] p, input int delay);
        int hi_n, lo_n;
        bit popped;
        logic [8:0] e;
        e = expect_lines(k, p);
        present(k, p);
        wait_strobe(hi_n);
        chk("R4 setup clocks", hi_n, int'(cfg_setup) + 1);
        chk("R2/R3 data lines", int'(pd), int'(e[7:0]));
        chk("R2/R3 host ack level", int'(host_ack), int'(e[8]));
        for (int i = 0; i < delay; i++) @(negedge clk);
        chk("R5 strobe low before ack", int'(host_clk), 0);
        chk("R5 no pop before ack", int'(in_ready), 0);
        ack_commit(lo_n, popped);
        in_valid = 1'b0;
        exp_cnt = (exp_cnt + 1) % (1 << CNT_W);
        chk("R5 sync latency", lo_n, 2);
        chk("R6 pop at commit", int'(popped), 1);
        chk("R6 done pulse", int'(byte_done), 1);
        chk("R6 counter step", int'(xcount), exp_cnt);
        @(negedge clk);
        chk("R6 done one cycle", int'(byte_done), 0);
        periph_ack = 1'b0;
        for (int i = 0; i < 4; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk("R1 strobe high", int'(host_clk), 1);
        chk("R1 host ack high", int'(host_ack), 1);
        chk("R1 counter zero", int'(xcount), 0);
        chk("R1 flags low", int'(byte_done | tmo_err | in_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 strobe high after release", int'(host_clk), 1);
    endtask

    task automatic t_kinds();
        cfg_setup = 3'd3;
        send_byte(2'b00, 8'hA5, 1);        // R2 data
        send_byte(2'b01, 8'hFF, 0);        // R3 count, bit 7 dropped
        send_byte(2'b10, 8'h00, 2);        // R3 channel 0
        send_byte(2'b11, 8'h7F, 1);        // R3 channel 127
        send_byte(2'b01, 8'h00, 3);        // R13 command after command
        send_byte(2'b00, 8'h80, 0);        // R13 data after command
    endtask

    task automatic t_setup_edges();
        cfg_setup = 3'd0;
        send_byte(2'b00, 8'h11, 1);        // R4 minimum
        cfg_setup = 3'd7;
        send_byte(2'b00, 8'h22, 1);        // R4 maximum
        cfg_setup = 3'd2;
    endtask

    task automatic t_hold_next();
        int hi_n, lo_n;
        bit popped;
        present(2'b00, 8'h3C);
        wait_strobe(hi_n);
        ack_commit(lo_n, popped);
        exp_cnt = (exp_cnt + 1) % (1 << CNT_W);
        in_kind = 2'b10;
        in_payload = 8'h05;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R7 lines held while ack high", int'(pd), 8'h3C);
            chk("R7 no pop while ack high", int'(in_ready), 0);
        end
        periph_ack = 1'b0;
        wait_strobe(hi_n);
        chk("R7 next byte after ack low", int'(pd), 8'h85);
        chk("R7 next is command", int'(host_ack), 0);
        ack_commit(lo_n, popped);
        in_valid = 1'b0;
        exp_cnt = (exp_cnt + 1) % (1 << CNT_W);
        chk("R13 count after pair", int'(xcount), exp_cnt);
        @(negedge clk);
        periph_ack = 1'b0;
        for (int i = 0; i < 4; i++) @(negedge clk);
    endtask

    task automatic t_abort();
        int hi_n;
        bit bad;
        // Abort as the acknowledge rises, before the strobe goes back high.
        present(2'b00, 8'h5A);
        wait_strobe(hi_n);
        periph_ack = 1'b1;
        abort_req = 1'b1;
        @(negedge clk);
        abort_req = 1'b0;
        in_valid = 1'b0;
        chk("R8 strobe back high", int'(host_clk), 1);
        bad = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (in_ready || byte_done || !host_clk) bad = 1'b1;
        end
        chk("R8 no pop or done", int'(bad), 0);
        chk("R8 counter unchanged", int'(xcount), exp_cnt);
        periph_ack = 1'b0;
        for (int i = 0; i < 4; i++) @(negedge clk);
        send_byte(2'b00, 8'h5A, 1);          // R8 retry counts once
        // Abort during setup.
        cfg_setup = 3'd5;
        present(2'b01, 8'h09);
        @(negedge clk);
        @(negedge clk);
        abort_req = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        abort_req = 1'b0;
        bad = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!host_clk || in_ready) bad = 1'b1;
        end
        chk("R8 setup abort no strobe", int'(bad), 0);
        chk("R8 setup abort no count", int'(xcount), exp_cnt);
        cfg_setup = 3'd2;
    endtask

    task automatic t_timeouts();
        int hi_n, lo_n, n;
        bit popped;
        // No acknowledge at all.
        present(2'b00, 8'h66);
        wait_strobe(hi_n);
        n = 1;
        @(negedge clk);
        while (!host_clk && n < 100) begin
            if (in_ready) popped = 1'b1;
            n++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk("R9 strobe low cycles", n, TMO + 1);
        chk("R9 error raised", int'(tmo_err), 1);
        chk("R9 nothing counted", int'(xcount), exp_cnt);
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk("R11 error sticky", int'(tmo_err), 1);
        // R11: next start clears it.
        present(2'b00, 8'h77);
        wait_strobe(hi_n);
        chk("R11 error cleared on start", int'(tmo_err), 0);
        // Acknowledge never falls.
        ack_commit(lo_n, popped);
        in_valid = 1'b0;
        exp_cnt = (exp_cnt + 1) % (1 << CNT_W);
        n = 0;
        while (!tmo_err && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R10 release wait cycles", n, TMO + 1);
        chk("R10 byte stays counted", int'(xcount), exp_cnt);
        chk("R10 strobe high", int'(host_clk), 1);
        periph_ack = 1'b0;
        for (int i = 0; i < 4; i++) @(negedge clk);
    endtask

    task automatic t_wrap();
        int start;
        start = int'(xcount);
        for (int i = 0; i < 16; i++) send_byte(2'b00, 8'(i * 13), i % 3);
        chk("R12 counter wraps", int'(xcount), start);
    endtask

    initial begin
        t_reset();
        t_kinds();
        t_setup_edges();
        t_hold_next();
        t_abort();
        t_timeouts();
        t_wrap();
        summary();
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end
endmodule